// File: doc/BRIEF.md
# Pipelined Byte-Write Burst SRAM

This block is a synthesizable single-port synchronous memory with a 32-bit word split into four byte lanes. Every input is sampled on the rising clock edge: chip enables, address strobes, write controls, address and write data. The read result then passes through an output register, so it appears one clock after the edge that registered its address. An output-valid flag runs alongside the read data through this pipeline. The array depth comes from the address-width parameter and is kept small for simulation.

An access begins with one of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, as the write controls decide. After the start, the advance input steps an internal 2-bit burst counter. Holding advance high suspends the burst and repeats the current address. The counter changes only the two lowest address bits and follows a linear or an interleaved order, chosen by a mode input. An output enable gates the read data on its way to the port.

Top module: `burst_sram`

## Requirements
- R1: A burst start (controller strobe low, or processor strobe low while `ce1_n` is low) selects the block only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other start deselects it. A deselecting start performs no access and gives no output, and later advance or suspend cycles also do nothing until the next selecting start.
- R2: With `ce1_n` high, a low controller strobe deselects the block. A low processor strobe is ignored and the cycle is treated as continue or suspend.
- R3: A burst started by the processor strobe (`ce1_n` low) is a read, whatever the write controls are.
- R4: A burst started with the processor strobe high and the controller strobe low is a write when the write controls select a write and a read otherwise. Continue and suspend cycles take their direction from the write controls in the same way.
- R5: `gw_n`=0 writes all four byte lanes, regardless of `bwe_n` and `bsel_n`.
- R6: With `gw_n`=1 and `bwe_n`=0, lane k (bits 8k+7:8k) is written when `bsel_n[k]`=0. If no lane is selected, or if `bwe_n`=1, the cycle is a read.
- R7: With both strobes high, `adv_n`=0 uses the next burst address and `adv_n`=1 reuses the current one. Address bits above bit 1 keep the value captured at burst start.
- R8: With `burst_ilv`=0, the low address bits follow (start + n) mod 4 for step n.
- R9: With `burst_ilv`=1, the low address bits follow start XOR n for step n.
- R10: Read data and `rvalid` are driven only while `oe_n` is low. Write cycles produce no output. While off, `rdata` is 0.
- R11: A read registered at clock edge k is on `rdata` with `rvalid`=1 after edge k+1. During and right after reset, `rvalid`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control pipeline |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| pstrb_n | input | 1 | Processor-side address strobe, starts a read |
| cstrb_n | input | 1 | Controller-side address strobe, starts read or write |
| adv_n | input | 1 | Burst advance, low steps the counter |
| gw_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte-write enable |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, 0 when off |
| rvalid | output | 1 | High when rdata carries read data |

## Verification
The bench checks the strobe-priority corners. A processor-strobe start with global write low must read; a design that wrote there would destroy the stored word and show no valid output. A processor strobe with `ce1_n` high must act as a suspend, and a design that restarted there would return the word at the new address. Burst order is checked by starting at an odd low address in both modes, so a counter that wraps wrongly or disturbs the upper address bits returns the wrong word. The bench also checks the following. Deselecting starts must be followed by advance cycles with write data, and the stored word must be unchanged. A byte write on alternate lanes, and cycles with enables but no lanes, catch swapped lane decoding. Output-enable toggling on a held read, and write bursts, catch output gating done at the wrong place.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;

    typedef enum logic [2:0] {
        K_IDLE,
        K_START,
        K_DESEL,
        K_NEXT,
        K_HOLD
    } kind_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } op_e;

    // low two address bits for burst step n from the start offset
    function automatic logic [1:0] burst_lo(input logic ilv,
                                            input logic [1:0] first,
                                            input logic [1:0] step);
        return ilv ? (first ^ step) : (first + step);
    endfunction

endpackage

// File: rtl/bsram_cmd_decode.sv
`timescale 1ns/1ps
module bsram_cmd_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             active,
    output kind_e            kind_o,
    output op_e              op_o,
    output logic [LANES-1:0] lanes_o
);

    logic             start_req;
    logic             chip_on;
    logic             proc_start;
    logic [LANES-1:0] want;

    always_comb begin
        proc_start = !pstrb_n && !ce1_n;
        start_req  = !cstrb_n || proc_start;
        chip_on    = !ce1_n && ce2 && !ce3_n;

        if (!gw_n) begin
            want = '1;
        end else if (!bwe_n) begin
            want = ~bsel_n;
        end else begin
            want = '0;
        end

        if (start_req) begin
            kind_o = chip_on ? K_START : K_DESEL;
        end else if (active) begin
            kind_o = adv_n ? K_HOLD : K_NEXT;
        end else begin
            kind_o = K_IDLE;
        end

        if (kind_o == K_IDLE || kind_o == K_DESEL) begin
            op_o = OP_NONE;
        end else if ((|want) && !(start_req && proc_start)) begin
            op_o = OP_WRITE;
        end else begin
            op_o = OP_READ;
        end

        lanes_o = (op_o == OP_WRITE) ? want : '0;
    end

endmodule

// File: rtl/bsram_burst.sv
`timescale 1ns/1ps
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  kind_e             kind_i,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              active_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic            active;
        logic [HI_W-1:0] hi;
        logic [1:0]      first;
        logic [1:0]      step;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        addr_o = {st_q.hi, burst_lo(ilv, st_q.first, st_q.step)};
        case (kind_i)
            K_START: begin
                st_d.active = 1'b1;
                st_d.hi     = addr_i[ADDR_W-1:2];
                st_d.first  = addr_i[1:0];
                st_d.step   = 2'd0;
                addr_o      = addr_i;
            end
            K_DESEL: begin
                st_d.active = 1'b0;
            end
            K_NEXT: begin
                st_d.step = st_q.step + 2'd1;
                addr_o    = {st_q.hi, burst_lo(ilv, st_q.first, st_q.step + 2'd1)};
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    // R1
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_i == K_DESEL |=> !st_q.active);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_i == K_HOLD |=> $stable(st_q.step) && $stable(st_q.hi));

    // R7
    next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_i == K_NEXT |=> (st_q.step == $past(st_q.step) + 2'd1) && $stable(st_q.hi));

endmodule

// File: rtl/bsram_core.sv
`timescale 1ns/1ps
module bsram_core
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_e                  op_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [8*LANES-1:0]   wdata_i,
    input  logic [LANES-1:0]     lanes_i,
    input  logic                 oe_n,
    output logic [8*LANES-1:0]   rdata_o,
    output logic                 rvalid_o
);

    localparam int DW    = 8 * LANES;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [LANES-1:0]  lanes;
    } in_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_t;

    in_t  in_d, in_q;
    out_t out_d, out_q;

    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        in_d.op    = op_i;
        in_d.addr  = addr_i;
        in_d.wdata = wdata_i;
        in_d.lanes = lanes_i;

        out_d.valid = (in_q.op == OP_READ);
        out_d.data  = (in_q.op == OP_READ) ? mem[in_q.addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            in_q  <= in_d;
            out_q <= out_d;
        end
    end

    always_ff @(posedge clk) begin
        if (in_q.op == OP_WRITE) begin
            for (int k = 0; k < LANES; k++) begin
                if (in_q.lanes[k]) begin
                    mem[in_q.addr][8*k +: 8] <= in_q.wdata[8*k +: 8];
                end
            end
        end
    end

    assign rvalid_o = out_q.valid && !oe_n;
    assign rdata_o  = rvalid_o ? out_q.data : '0;

    // R11
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_q.op == OP_READ |=> out_q.valid);

    // R10
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_q.op == OP_WRITE |=> !out_q.valid);

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 pstrb_n,
    input  logic                 cstrb_n,
    input  logic                 adv_n,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [LANES-1:0]     bsel_n,
    input  logic                 oe_n,
    input  logic                 burst_ilv,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [8*LANES-1:0]   wdata,
    output logic [8*LANES-1:0]   rdata,
    output logic                 rvalid
);

    kind_e             kind;
    op_e               op;
    logic [LANES-1:0]  lanes;
    logic              active;
    logic [ADDR_W-1:0] eff_addr;

    bsram_cmd_decode #(.LANES(LANES)) u_dec (
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .pstrb_n (pstrb_n),
        .cstrb_n (cstrb_n),
        .adv_n   (adv_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .active  (active),
        .kind_o  (kind),
        .op_o    (op),
        .lanes_o (lanes)
    );

    bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_i   (kind),
        .ilv      (burst_ilv),
        .addr_i   (addr),
        .active_o (active),
        .addr_o   (eff_addr)
    );

    bsram_core #(.ADDR_W(ADDR_W), .LANES(LANES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .addr_i   (eff_addr),
        .wdata_i  (wdata),
        .lanes_i  (lanes),
        .oe_n     (oe_n),
        .rdata_o  (rdata),
        .rvalid_o (rvalid)
    );

    // R3
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n && !ce1_n && op != OP_NONE) |-> op == OP_READ);

    // R5
    gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && !gw_n) |-> (&lanes));

    // R2
    ce1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && cstrb_n) |-> (kind != K_START && kind != K_DESEL));

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic        pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0, burst_ilv = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .burst_ilv(burst_ilv),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct packed {
        logic        ps_n;
        logic        cc_n;
        logic        adv;
        logic        gw;
        logic        bwe;
        logic [3:0]  bs;
        logic        oe;
        logic [5:0]  a;
        logic [31:0] wd;
        logic        ev;
        logic [31:0] ed;
    } vec_t;

    // Each row is applied before an edge; expectation is the output seen
    // just after applying it (result of the row two steps earlier).
    // R4 R5 write bursts, R6 lanes 0 and 2, R3 forced read, R7 R8 continue
    // and suspend, R10 output enable, R11 latency.
    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1,0,1,0,1,4'hF,0, 8,32'hA0A0A0A0,0,32'h0},
        '{1,1,0,0,1,4'hF,0, 0,32'hA1A1A1A1,0,32'h0},
        '{1,1,0,0,1,4'hF,0, 0,32'hA2A2A2A2,0,32'h0},
        '{1,1,0,0,1,4'hF,0, 0,32'hA3A3A3A3,0,32'h0},
        '{1,0,1,0,1,4'hF,0,12,32'h11223344,0,32'h0},
        '{1,1,1,1,0,4'hA,0, 0,32'hAABBCCDD,0,32'h0},
        '{0,1,1,0,1,4'hF,0, 8,32'hDEADBEEF,0,32'h0},
        '{1,1,0,1,1,4'hF,0, 0,32'h0,0,32'h0},
        '{1,1,0,1,1,4'hF,0, 0,32'h0,1,32'hA0A0A0A0},
        '{1,1,1,1,1,4'hF,0, 0,32'h0,1,32'hA1A1A1A1},
        '{1,1,0,1,1,4'hF,0, 0,32'h0,1,32'hA2A2A2A2},
        '{1,1,0,1,1,4'hF,0, 0,32'h0,1,32'hA2A2A2A2},
        '{1,0,1,1,1,4'hF,0,12,32'h0,1,32'hA3A3A3A3},
        '{1,1,1,1,1,4'hF,1, 0,32'h0,0,32'h0},
        '{1,1,1,1,1,4'hF,0, 0,32'h0,1,32'h11BB33DD},
        '{1,0,1,1,0,4'hF,0,10,32'h0,1,32'h11BB33DD},
        '{1,1,1,1,1,4'hF,0, 0,32'h0,1,32'h11BB33DD},
        '{1,1,1,1,1,4'hF,0, 0,32'h0,1,32'hA2A2A2A2}
    };

    task automatic check(input string tag, input logic ev, input logic [31:0] ed);
        #1;
        n_chk++;
        if (rvalid !== ev || rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic set_ctl(input logic ps, input logic cc, input logic ad,
                           input logic gw, input logic bw, input logic [3:0] bs,
                           input logic [5:0] a, input logic [31:0] wd);
        @(negedge clk);
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; oe_n = 1'b0;
        pstrb_n = ps; cstrb_n = cc; adv_n = ad; gw_n = gw; bwe_n = bw;
        bsel_n = bs; addr = a; wdata = wd;
    endtask

    task automatic wr_start(input logic [5:0] a, input logic [31:0] wd);
        set_ctl(1, 0, 1, 0, 1, 4'hF, a, wd);
    endtask
    task automatic wr_adv(input logic [31:0] wd);
        set_ctl(1, 1, 0, 0, 1, 4'hF, 6'd0, wd);
    endtask
    task automatic rd_p(input logic [5:0] a);
        set_ctl(0, 1, 1, 1, 1, 4'hF, a, 32'h0);
    endtask
    task automatic rd_c(input logic [5:0] a);
        set_ctl(1, 0, 1, 1, 1, 4'hF, a, 32'h0);
    endtask
    task automatic rd_adv();
        set_ctl(1, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0);
    endtask
    task automatic hold();
        set_ctl(1, 1, 1, 1, 1, 4'hF, 6'd0, 32'h0);
    endtask
    task automatic desel();
        set_ctl(1, 0, 1, 1, 1, 4'hF, 6'd0, 32'h0);
        ce2 = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        hold();
        check("R11 after reset", 1'b0, 32'h0);
        hold();

        for (int i = 0; i < NV; i++) begin
            set_ctl(TBL[i].ps_n, TBL[i].cc_n, TBL[i].adv, TBL[i].gw, TBL[i].bwe,
                    TBL[i].bs, TBL[i].a, TBL[i].wd);
            oe_n = TBL[i].oe;
            check($sformatf("table row %0d (R3 R4 R5 R6 R7 R8 R10 R11)", i),
                  TBL[i].ev, TBL[i].ed);
        end

        // fill words 12..15 with C0..C3 through a linear write burst
        desel();
        wr_start(6'd12, 32'hC0C0C0C0);
        wr_adv(32'hC1C1C1C1);
        wr_adv(32'hC2C2C2C2);
        wr_adv(32'hC3C3C3C3);

        // R9 interleaved from offset 1: 13,12,15,14
        desel();
        burst_ilv = 1'b1;
        rd_p(6'd13);
        rd_adv();
        rd_adv();  check("R9 step0", 1, 32'hC1C1C1C1);
        rd_adv();  check("R9 step1", 1, 32'hC0C0C0C0);
        desel();   check("R9 step2", 1, 32'hC3C3C3C3);
        hold();    check("R9 step3", 1, 32'hC2C2C2C2);
        burst_ilv = 1'b0;

        // R8 linear from offset 1: 13,14,15,12 (R7 upper bits kept)
        rd_c(6'd13);
        rd_adv();
        rd_adv();  check("R8 step0", 1, 32'hC1C1C1C1);
        rd_adv();  check("R8 step1", 1, 32'hC2C2C2C2);
        desel();   check("R8 step2", 1, 32'hC3C3C3C3);
        hold();    check("R7 R8 wrap", 1, 32'hC0C0C0C0);

        // R2 processor strobe ignored while ce1_n high
        rd_c(6'd15);
        hold(); ce1_n = 1'b1; pstrb_n = 1'b0; addr = 6'd12;
        desel(); ce2 = 1'b1; ce1_n = 1'b1;
        check("R11 read 15", 1, 32'hC3C3C3C3);
        rd_adv();  check("R2 strobe ignored", 1, 32'hC3C3C3C3);
        hold();    check("R2 ce1 deselect", 0, 32'h0);
        hold();    check("R1 advance after deselect", 0, 32'h0);

        // R1 deselected start performs no write
        wr_start(6'd12, 32'hFFFFFFFF); ce2 = 1'b0;
        wr_adv(32'hEEEEEEEE);
        rd_c(6'd12); check("R1 no access", 0, 32'h0);
        hold();      check("R1 no access 2", 0, 32'h0);
        rd_p(6'd13); ce3_n = 1'b1;
        check("R1 word intact", 1, 32'hC0C0C0C0);
        rd_adv();    check("R1 hold before deselect", 1, 32'hC0C0C0C0);
        hold();      check("R1 ce3 deselect", 0, 32'h0);
        hold();      check("R1 idle", 0, 32'h0);

        // R10 output enable on a held read, and writes give no output
        rd_c(6'd14);
        hold();
        hold(); oe_n = 1'b1;
        check("R10 oe high", 0, 32'h0);
        hold();    check("R10 oe low", 1, 32'hC2C2C2C2);
        wr_start(6'd20, 32'h12345678);
        check("R10 read before write", 1, 32'hC2C2C2C2);
        wr_adv(32'h9ABCDEF0);
        check("R10 read before write 2", 1, 32'hC2C2C2C2);
        desel();   check("R10 write quiet", 0, 32'h0);
        hold();    check("R10 write quiet 2", 0, 32'h0);

        // R6 enable without write enables reads; R4 direction from controls
        set_ctl(1, 0, 1, 1, 1, 4'h0, 6'd12, 32'h0);
        desel();
        hold();    check("R6 bwe high reads", 1, 32'hC0C0C0C0);
        rd_c(6'd20);
        hold();
        desel();   check("R4 write landed", 1, 32'h12345678);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule